// File: doc/BRIEF.md
# Serial EEPROM Slave Model

This block behaves as a small byte-addressed serial EEPROM attached to an SPI bus in mode 0 (clock idles low, data sampled on the rising edge and changed on the falling edge). A host lowers chip select and sends an 8-bit instruction. An address follows for the data instructions. The block then either streams array bytes back, accepts bytes into the array, or reports or updates a status byte. The bus pins are sampled by the block's own system clock through two-flop synchronisers. The bus clock must therefore hold each level for at least three system clocks.

Writes are gated by a write-enable latch. A write or status update starts a programming interval when chip select rises. For a parameterised number of system clocks the block then reports itself busy. During that interval it answers only status reads, and when the interval ends it clears the latch. Write addresses advance only within the current page, while read addresses run through the whole array. In the single-address-byte configuration, an optional mode takes address bit 8 from bit 3 of the read or write instruction, so a 512-byte array can be reached with one address byte.

Top module: `spi_eeprom_dev`

## Requirements
- R1: After reset the status byte reads 0x00 and MISO is low.
- R2: Instruction 0x06 sets the write-enable latch, which is reported as status bit 1. Instruction 0x04 clears it.
- R3: Instruction 0x05 returns the status byte on MISO, and repeats it for every further byte while chip select stays low. The layout is bit 0 busy, bit 1 write-enable latch, bits 2 and 3 block-protect, bit 7 protect-enable, and the remaining bits 0.
- R4: Instruction 0x01, given while the latch is set, stores bits 7, 3 and 2 of its data byte into status bits 7, 3 and 2. Without the latch the instruction leaves the status unchanged.
- R5: Instruction 0x03 is followed by ADDR_BYTES address bytes, most significant byte first. Data bytes are then returned from consecutive addresses, wrapping from the last array byte to address 0.
- R6: Instruction 0x02 while the latch is clear changes no array byte and starts no busy interval.
- R7: During a write, each data byte goes to the current address, and the address then advances modulo PAGE_BYTES within its page.
- R8: When chip select rises after a write or status update that received at least one data byte, status bit 0 reads 1 for BUSY_CYCLES clocks. It then returns to 0 together with the write-enable latch.
- R9: While busy, only instruction 0x05 is answered. Reads return 0x00 on MISO, and latch, write and status-write instructions have no effect.
- R10: With the ninth-bit mode on and one address byte, instructions 0x0B and 0x0A read and write at address 256 plus the address byte. Instructions 0x03 and 0x02 reach addresses 0 to 255.
- R11: MISO presents the data MSB first and changes only after a falling SCLK edge. It is held low while chip select is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples the bus |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock, mode 0 |
| csN | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |

## Verification
A corrupted write-enable latch or busy counter shows up in the status byte within one status read, as a wrong bit 0 or bit 1. It also shows up as array bytes that change when they should not, visible on the next read after the programming interval. A wrong address register or page step appears as the wrong byte on MISO in the first data byte of a later read. A wrong transmit shift register shows as mis-ordered bits within that same byte.

// File: rtl/spi_eeprom_pkg.sv
package spi_eeprom_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_CMD, PH_ADDR, PH_RDATA, PH_WDATA, PH_STATR, PH_STATW, PH_IGNORE
  } phase_t;

  // strobes from control to datapath, valid for one system clock
  typedef struct packed {
    logic       memWrite;   // store dataByte at the current address
    logic       pageStep;   // advance address within its page
    logic       addrSet;    // load address from the assembled value
    logic       addrStep;   // advance address across the array
    logic       statWrite;  // update the protect bits from dataByte
    logic       txLoad;     // load the transmit register
    logic       txShift;    // shift the transmit register by one bit
    logic       selStatus;  // transmit source is the status byte
    logic [7:0] dataByte;
  } dp_strobe_t;

endpackage

// File: rtl/spi_eeprom_ctrl.sv
module spi_eeprom_ctrl
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_BYTES  = 1,
  parameter int AW          = 9,
  parameter bit USE9        = 1'b1,
  parameter int BUSY_CYCLES = 400
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            sclk,
  input  logic            csN,
  input  logic            mosi,
  output dp_strobe_t      strb,
  output logic [AW-1:0]   addrIn,
  output logic            wel,
  output logic            busy,
  output logic            drive
);
  localparam int ACC_W = 8 * ADDR_BYTES + 1;
  localparam int ACW   = $clog2(ADDR_BYTES + 1);
  localparam int BW    = $clog2(BUSY_CYCLES + 1);

  logic [1:0] sclkSy, csSy, mosiSy;
  logic       sclkPrev, csPrev;
  logic       sclkS, csS, mosiS;
  logic       rise, fall, csFall, csRise, byteDone;
  logic [7:0] byteNow;

  phase_t           phase;
  logic [2:0]       bitCnt;
  logic [6:0]       shiftIn;
  logic [ACC_W-1:0] addrAcc, accNext;
  logic [ACW-1:0]   addrCnt;
  logic             isWrite, txPend, armed;
  logic [BW-1:0]    busyCnt;
  logic             cmdRead, cmdWrite, cmdWren, cmdWrdi, cmdRdsr, cmdWrsr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclkSy <= 2'b00; csSy <= 2'b11; mosiSy <= 2'b00;
      sclkPrev <= 1'b0; csPrev <= 1'b1;
    end else begin
      sclkSy <= {sclkSy[0], sclk};
      csSy   <= {csSy[0], csN};
      mosiSy <= {mosiSy[0], mosi};
      sclkPrev <= sclkSy[1];
      csPrev   <= csSy[1];
    end
  end

  assign sclkS    = sclkSy[1];
  assign csS      = csSy[1];
  assign mosiS    = mosiSy[1];
  assign rise     = !csS && sclkS && !sclkPrev;
  assign fall     = !csS && !sclkS && sclkPrev;
  assign csFall   = csPrev && !csS;
  assign csRise   = !csPrev && csS;
  assign byteNow  = {shiftIn, mosiS};
  assign byteDone = rise && (bitCnt == 3'd7);
  assign accNext  = {addrAcc[ACC_W-9:0], byteNow};
  assign addrIn   = accNext[AW-1:0];
  assign busy     = (busyCnt != '0);
  assign drive    = (phase == PH_RDATA) || (phase == PH_STATR);

  assign cmdRead  = (byteNow == 8'h03) || (USE9 && byteNow == 8'h0B);
  assign cmdWrite = (byteNow == 8'h02) || (USE9 && byteNow == 8'h0A);
  assign cmdWren  = (byteNow == 8'h06);
  assign cmdWrdi  = (byteNow == 8'h04);
  assign cmdRdsr  = (byteNow == 8'h05);
  assign cmdWrsr  = (byteNow == 8'h01);

  always_comb begin
    strb = '0;
    strb.dataByte  = byteNow;
    strb.selStatus = (phase == PH_STATR);
    if (byteDone) begin
      case (phase)
        PH_ADDR:  strb.addrSet = (addrCnt == ACW'(ADDR_BYTES - 1));
        PH_WDATA: begin strb.memWrite = 1'b1; strb.pageStep = 1'b1; end
        PH_STATW: strb.statWrite = 1'b1;
        default: ;
      endcase
    end
    if (fall) begin
      if (txPend) begin
        strb.txLoad   = 1'b1;
        strb.addrStep = (phase == PH_RDATA);
      end else begin
        strb.txShift = 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase <= PH_IDLE; bitCnt <= '0; shiftIn <= '0;
      addrAcc <= '0; addrCnt <= '0; isWrite <= 1'b0;
      txPend <= 1'b0; armed <= 1'b0; wel <= 1'b0; busyCnt <= '0;
    end else begin
      if (busy) begin
        busyCnt <= busyCnt - 1'b1;
        if (busyCnt == BW'(1)) wel <= 1'b0;
      end
      if (csFall) begin
        phase <= PH_CMD; bitCnt <= '0; txPend <= 1'b0; armed <= 1'b0;
      end else if (csRise) begin
        phase <= PH_IDLE; armed <= 1'b0;
        if (armed) busyCnt <= BW'(BUSY_CYCLES);
      end else if (!csS) begin
        if (rise) begin
          shiftIn <= byteNow[6:0];
          bitCnt  <= bitCnt + 1'b1;
        end
        if (fall && txPend) txPend <= 1'b0;
        if (byteDone) begin
          case (phase)
            PH_CMD: begin
              addrCnt <= '0;
              addrAcc <= USE9 ? ACC_W'(byteNow[3]) : '0;
              phase   <= PH_IGNORE;
              if (busy) begin
                if (cmdRdsr) begin phase <= PH_STATR; txPend <= 1'b1; end
              end else if (cmdWren) wel <= 1'b1;
              else if (cmdWrdi) wel <= 1'b0;
              else if (cmdRdsr) begin phase <= PH_STATR; txPend <= 1'b1; end
              else if (cmdWrsr && wel) phase <= PH_STATW;
              else if (cmdRead) begin phase <= PH_ADDR; isWrite <= 1'b0; end
              else if (cmdWrite && wel) begin phase <= PH_ADDR; isWrite <= 1'b1; end
            end
            PH_ADDR: begin
              addrAcc <= accNext;
              addrCnt <= addrCnt + 1'b1;
              if (addrCnt == ACW'(ADDR_BYTES - 1)) begin
                phase  <= isWrite ? PH_WDATA : PH_RDATA;
                txPend <= !isWrite;
              end
            end
            PH_RDATA, PH_STATR: txPend <= 1'b1;
            PH_WDATA: armed <= 1'b1;
            PH_STATW: begin armed <= 1'b1; phase <= PH_IGNORE; end
            default: ;
          endcase
        end
      end
    end
  end

endmodule

// File: rtl/spi_eeprom_dp.sv
module spi_eeprom_dp
  import spi_eeprom_pkg::*;
#(
  parameter int MEM_BYTES = 512,
  parameter int AW        = 9,
  parameter int PW        = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  dp_strobe_t    strb,
  input  logic [AW-1:0] addrIn,
  input  logic          wel,
  input  logic          busy,
  input  logic          drive,
  output logic          miso
);
  logic [7:0]    mem [MEM_BYTES];
  logic [AW-1:0] addr, pageNext;
  logic [2:0]    protBits;   // protect-enable, block-protect high, low
  logic [7:0]    txReg, status;

  assign status = {protBits[2], 3'b000, protBits[1], protBits[0], wel, busy};

  generate
    if (PW < AW) begin : g_split
      assign pageNext = {addr[AW-1:PW], addr[PW-1:0] + 1'b1};
    end else begin : g_whole
      assign pageNext = addr + 1'b1;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (strb.memWrite) mem[addr] <= strb.dataByte;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0; protBits <= '0; txReg <= '0;
    end else begin
      if (strb.addrSet)       addr <= addrIn;
      else if (strb.pageStep) addr <= pageNext;
      else if (strb.addrStep) addr <= addr + 1'b1;
      if (strb.statWrite)
        protBits <= {strb.dataByte[7], strb.dataByte[3], strb.dataByte[2]};
      if (strb.txLoad)       txReg <= strb.selStatus ? status : mem[addr];
      else if (strb.txShift) txReg <= {txReg[6:0], 1'b0};
    end
  end

  assign miso = drive & txReg[7];

endmodule

// File: rtl/spi_eeprom_dev.sv
module spi_eeprom_dev
  import spi_eeprom_pkg::*;
#(
  parameter int ADDR_BYTES     = 1,
  parameter int NINTH_ADDR_BIT = 1,
  parameter int MEM_BYTES      = 512,
  parameter int PAGE_BYTES     = 16,
  parameter int BUSY_CYCLES    = 400
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk,
  input  logic csN,
  input  logic mosi,
  output logic miso
);
  localparam int AW   = $clog2(MEM_BYTES);
  localparam int PW   = $clog2(PAGE_BYTES);
  localparam bit USE9 = (ADDR_BYTES == 1) && (NINTH_ADDR_BIT != 0);

  dp_strobe_t    strb;
  logic [AW-1:0] addrIn;
  logic          wel, busy, drive;

  spi_eeprom_ctrl #(
    .ADDR_BYTES(ADDR_BYTES), .AW(AW), .USE9(USE9), .BUSY_CYCLES(BUSY_CYCLES)
  ) u_ctrl (
    .clk(clk), .rst(rst), .sclk(sclk), .csN(csN), .mosi(mosi),
    .strb(strb), .addrIn(addrIn), .wel(wel), .busy(busy), .drive(drive)
  );

  spi_eeprom_dp #(
    .MEM_BYTES(MEM_BYTES), .AW(AW), .PW(PW)
  ) u_dp (
    .clk(clk), .rst(rst), .strb(strb), .addrIn(addrIn),
    .wel(wel), .busy(busy), .drive(drive), .miso(miso)
  );

endmodule

// File: rtl/spi_eeprom_chk.sv
module spi_eeprom_chk
  import spi_eeprom_pkg::*;
(
  input logic       clk,
  input logic       rst,
  input logic       csN,
  input logic       miso,
  input logic       wel,
  input logic       busy,
  input dp_strobe_t strb
);
  // R6: an array store only happens with the latch set
  a_r6_store_needs_wel: assert property (@(posedge clk) disable iff (rst)
    strb.memWrite |-> wel);

  // R9: no store of array or status while programming
  a_r9_no_store_busy: assert property (@(posedge clk) disable iff (rst)
    (strb.memWrite || strb.statWrite) |-> !busy);

  // R9: latch cannot be changed during the interval
  a_r9_wel_frozen_busy: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(wel));

  // R8: latch is gone once the interval ends
  a_r8_wel_drops_at_done: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> !wel);

  // R8: an interval only begins from an enabled state
  a_r8_busy_needs_wel: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> wel);

  // R11: quiet output while deselected
  a_r11_quiet_deselected: assert property (@(posedge clk) disable iff (rst)
    (csN && $past(csN) && $past(csN, 2) && $past(csN, 3)) |-> !miso);

  // R3: at most one datapath action per clock
  a_r3_one_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({strb.memWrite, strb.statWrite, strb.txLoad}));

endmodule

bind spi_eeprom_dev spi_eeprom_chk u_chk (
  .clk(clk), .rst(rst), .csN(csN), .miso(miso),
  .wel(wel), .busy(busy), .strb(strb)
);

// File: tb/spi_eeprom_dev_tb.sv
module spi_eeprom_dev_tb;
  localparam int BUSY = 1600;
  localparam int HALF = 8;

  logic clk = 1'b0, rst = 1'b1, sclk = 1'b0, csN = 1'b1, mosi = 1'b0;
  logic miso;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  spi_eeprom_dev #(.ADDR_BYTES(1), .NINTH_ADDR_BIT(1), .MEM_BYTES(512),
                   .PAGE_BYTES(16), .BUSY_CYCLES(BUSY))
    u_dut (.clk(clk), .rst(rst), .sclk(sclk), .csN(csN), .mosi(mosi), .miso(miso));

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic sel();
    @(negedge clk); csN = 1'b0;
    repeat (HALF) @(negedge clk);
  endtask

  task automatic desel();
    repeat (HALF) @(negedge clk); csN = 1'b1;
    repeat (2 * HALF) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] tx, output logic [7:0] rx);
    for (int i = 7; i >= 0; i--) begin
      @(negedge clk); mosi = tx[i];
      repeat (HALF) @(negedge clk); sclk = 1'b1; rx[i] = miso;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
  endtask

  task automatic cmd1(input logic [7:0] c);
    logic [7:0] d;
    sel(); xfer(c, d); desel();
  endtask

  task automatic rdStatus(output logic [7:0] s);
    logic [7:0] d;
    sel(); xfer(8'h05, d); xfer(8'h00, s); desel();
  endtask

  task automatic memWr(input logic [7:0] c, input logic [7:0] a,
                       input logic [7:0] dat [4], input int n);
    logic [7:0] d;
    sel(); xfer(c, d); xfer(a, d);
    for (int i = 0; i < n; i++) xfer(dat[i], d);
    desel();
  endtask

  task automatic memRd(input logic [7:0] c, input logic [7:0] a,
                       input int n, output logic [7:0] r [4]);
    logic [7:0] d;
    sel(); xfer(c, d); xfer(a, d);
    for (int i = 0; i < n; i++) xfer(8'h00, r[i]);
    desel();
  endtask

  task automatic waitIdle();
    repeat (BUSY + 200) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] s;
    chk("R1 miso low after reset", {7'd0, miso}, 8'h00);
    chk("R11 miso low deselected", {7'd0, miso}, 8'h00);
    rdStatus(s); chk("R1 reset status", s, 8'h00);
  endtask

  task automatic t_latch();
    logic [7:0] s;
    cmd1(8'h06); rdStatus(s); chk("R2 latch set", s, 8'h02);
    cmd1(8'h04); rdStatus(s); chk("R2 latch clear", s, 8'h00);
  endtask

  task automatic t_basic();
    logic [7:0] s, r [4], w [4];
    w = '{8'h55, 8'h00, 8'h00, 8'h00};
    cmd1(8'h06); memWr(8'h02, 8'h10, w, 1); waitIdle();
    rdStatus(s); chk("R8 latch cleared after program", s, 8'h00);
    memRd(8'h03, 8'h10, 1, r); chk("R5 read back 0x10", r[0], 8'h55);
  endtask

  task automatic t_noWel();
    logic [7:0] s, r [4], w [4];
    w = '{8'hAA, 8'h00, 8'h00, 8'h00};
    memWr(8'h02, 8'h10, w, 1);
    rdStatus(s); chk("R6 no busy without latch", s, 8'h00);
    memRd(8'h03, 8'h10, 1, r); chk("R6 byte unchanged", r[0], 8'h55);
  endtask

  task automatic t_pageBusy();
    logic [7:0] s, d, r [4], w [4];
    w = '{8'h11, 8'h22, 8'h33, 8'h44};
    cmd1(8'h06); memWr(8'h02, 8'h2E, w, 4);
    sel(); xfer(8'h05, d); xfer(8'h00, s); chk("R8 busy status", s, 8'h03);
    xfer(8'h00, s); chk("R3 status repeats", s, 8'h03); desel();
    memRd(8'h03, 8'h2E, 1, r); chk("R9 read while busy gives zero", r[0], 8'h00);
    cmd1(8'h04); rdStatus(s); chk("R9 latch clear ignored while busy", s, 8'h03);
    waitIdle();
    rdStatus(s); chk("R8 idle after interval", s, 8'h00);
    memRd(8'h03, 8'h20, 2, r);
    chk("R7 wrapped byte at 0x20", r[0], 8'h33);
    chk("R7 wrapped byte at 0x21", r[1], 8'h44);
    memRd(8'h03, 8'h2E, 2, r);
    chk("R7 byte at 0x2E", r[0], 8'h11);
    chk("R11 byte at 0x2F msb first", r[1], 8'h22);
  endtask

  task automatic t_ninth();
    logic [7:0] r [4], w [4];
    w = '{8'h77, 8'h00, 8'h00, 8'h00};
    cmd1(8'h06); memWr(8'h0A, 8'h10, w, 1); waitIdle();
    memRd(8'h0B, 8'h10, 1, r); chk("R10 upper half 0x110", r[0], 8'h77);
    memRd(8'h03, 8'h10, 1, r); chk("R10 lower half 0x010", r[0], 8'h55);
  endtask

  task automatic t_arrayWrap();
    logic [7:0] r [4], w [4];
    w = '{8'hC3, 8'h00, 8'h00, 8'h00};
    cmd1(8'h06); memWr(8'h0A, 8'hFF, w, 1); waitIdle();
    w = '{8'h3C, 8'h00, 8'h00, 8'h00};
    cmd1(8'h06); memWr(8'h02, 8'h00, w, 1); waitIdle();
    memRd(8'h0B, 8'hFF, 2, r);
    chk("R5 last array byte", r[0], 8'hC3);
    chk("R5 wrap to address 0", r[1], 8'h3C);
  endtask

  task automatic t_status();
    logic [7:0] s, d;
    cmd1(8'h06); sel(); xfer(8'h01, d); xfer(8'hFF, d); desel(); waitIdle();
    rdStatus(s); chk("R4 protect bits stored", s, 8'h8C);
    sel(); xfer(8'h01, d); xfer(8'h00, d); desel();
    rdStatus(s); chk("R4 status write without latch ignored", s, 8'h8C);
    cmd1(8'h06); rdStatus(s); chk("R3 status with latch", s, 8'h8E);
    sel(); xfer(8'h01, d); xfer(8'h00, d); desel(); waitIdle();
    rdStatus(s); chk("R4 protect bits cleared", s, 8'h00);
  endtask

  initial begin
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (10) @(negedge clk);
    t_reset();
    t_latch();
    t_basic();
    t_noWel();
    t_pageBusy();
    t_ninth();
    t_arrayWrap();
    t_status();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule